// File: doc/BRIEF.md
# Dual-Subarray Lockstep MAC Engine

This block is a small output-stationary matrix-multiply engine. Its 4×4 grid of multiply-accumulate elements is built as two 4×2 subarrays, a primary and a shadow. An output tile is formed over `DEPTH` operand beats. Each beat carries one A value per row and one B value per column for all four columns. The operands of a tile go into a local buffer first. The engine then plays them from that buffer into the subarrays, so a tile can be computed again without taking new input.

The mode is taken with the first beat of each tile. In lockstep mode both subarrays use the A values and the lower two B columns. The shadow receives every operand one cycle after the primary. The primary accumulators pass through one register stage so that they line up with the shadow, and the two are compared bit for bit on every compute cycle. A mismatch replays the same tile from the buffer. A second mismatch on that tile is declared unrecoverable and the tile is dropped. In split mode the primary computes output tile 0 from B columns 0–1 and the shadow computes output tile 1 from B columns 2–3, and no comparison is made.

A fault-injection input flips bit 0 of primary element (0,0) on any compute cycle in which it is held high. This lets a fault campaign provoke mismatches.

Top module: `dual_lockstep_mac`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0, `err_o`=0, `fatal_o`=0, `mism_cnt_o`=0 and `replay_o`=0.
- R2: With `mode_i`=1 (lockstep) on a tile's first beat, the engine emits one result with `out_tile`=0. Element (r,c) sits at `out_data[(r*2+c)*ACC_W +: ACC_W]` and equals the sum over the tile's beats of `in_a[r*8+:8]*in_b[c*8+:8]` (unsigned), for c in 0..1.
- R3: With `mode_i`=0 (split) on the first beat, the engine emits two results on consecutive cycles. The first has `out_tile`=0 and uses B columns 0..1. The second has `out_tile`=1 and uses B columns 2..3.
- R4: `mode_i` is sampled only with a tile's first accepted beat. Changes on later beats or while the engine computes have no effect on that tile.
- R5: In lockstep mode, a mismatch between the delayed primary and the shadow replays the tile. The engine then emits the correct result, sets the sticky `err_o`, adds 1 to `mism_cnt_o`, and holds `replay_o` high during the replay pass.
- R6: A clean tile's result is valid DEPTH+2 rising edges after the edge that accepts its last beat. A tile that needs one replay produces its result within 100 cycles.
- R7: A mismatch in the replay pass sets the sticky `fatal_o`, adds a second count, and emits no result for that tile.
- R8: In split mode an injected fault is not detected. The fault shows in tile 0 element (0,0), and `mism_cnt_o` and `err_o` are unchanged.
- R9: `in_ready` is low whenever a result is being emitted or a tile is being computed.
- R10: `err_o` and `fatal_o` stay set until reset, and the engine keeps producing correct results after `fatal_o` is set.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 = lockstep, 0 = split; sampled on a tile's first beat |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Engine accepts operand beats |
| in_a | input | 32 | Four 8-bit row operands, row r at bits r*8 |
| in_b | input | 32 | Four 8-bit column operands, column c at bits c*8 |
| fault_i | input | 1 | Flip bit 0 of primary element (0,0) on compute cycles |
| out_valid | output | 1 | Result tile valid (one cycle) |
| out_tile | output | 1 | Tile index of the result |
| out_data | output | 152 | Eight 19-bit accumulators, element (r,c) at (r*2+c)*19 |
| replay_o | output | 1 | High during a replay pass |
| err_o | output | 1 | Sticky: a mismatch was seen |
| fatal_o | output | 1 | Sticky: a replay also mismatched |
| mism_cnt_o | output | 8 | Saturating count of failed comparison passes |

## Verification
Suppose the delay stage or the shadow operand skew slips by one cycle. The comparison would then mismatch on every lockstep tile, and the first clean tile would show a raised `err_o` and a late result at once. A comparator that stays silent shows up on the first fault-injected tile: `mism_cnt_o` does not move and the output carries the flipped bit. A mode register that samples at the wrong time shows up on the same tile: the mid-tile toggles on `mode_i` give the wrong number of result beats or the wrong B columns.

// File: rtl/dlm_pkg.sv
// Shared types for the dual-subarray lockstep MAC engine.
package dlm_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_OUT0 = 2'd2,
        ST_OUT1 = 2'd3
    } dlm_state_e;
endpackage

// File: rtl/op_buffer.sv
// Tile operand store: holds DEPTH beats written during load.
// The sequencers read it in place on every pass.
// Assumes reads are used only for indices below DEPTH.
module op_buffer #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Capture one operand beat per accepted input.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mac_subarray.sv
// ROWS x COLS output-stationary MAC grid.
// Element (r,c) adds a[r]*b[c] each enabled cycle.
// flip XORs bit 0 of element (0,0) after its update, for fault injection.
// clr takes priority over en.
module mac_subarray #(
    parameter int ROWS  = 4,
    parameter int COLS  = 2,
    parameter int DW    = 8,
    parameter int ACC_W = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic                       flip,
    input  logic [ROWS*DW-1:0]         a,
    input  logic [COLS*DW-1:0]         b,
    output logic [ROWS*COLS*ACC_W-1:0] acc
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam bit FIRST = (r == 0) && (c == 0);
            logic [ACC_W-1:0] acc_q;
            logic [2*DW-1:0]  prod;
            logic             f;
            assign prod = a[r*DW +: DW] * b[c*DW +: DW];
            assign f    = flip & FIRST;

            // Accumulate the element's product, cleared at tile start.
            always_ff @(posedge clk) begin
                if (!rst_n)   acc_q <= '0;
                else if (clr) acc_q <= '0;
                else if (en)  acc_q <= (acc_q + ACC_W'(prod)) ^ {{(ACC_W-1){1'b0}}, f};
            end

            assign acc[(r*COLS+c)*ACC_W +: ACC_W] = acc_q;
        end
    end
endmodule

// File: rtl/lockstep_ctrl.sv
// Tile controller: load, compute pass(es), result beats.
// It latches the mode with the first beat and sequences DEPTH+2 compute steps.
// It decides replay or abort from the comparator, and keeps the sticky status.
module lockstep_ctrl #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8,
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_i,
    input  logic             mism,
    output logic             in_ready,
    output logic             wr_en,
    output logic [CW-1:0]    step,
    output logic             p_en,
    output logic             clr,
    output logic             out_valid,
    output logic             out_tile,
    output logic             replay,
    output logic             err,
    output logic             fatal,
    output logic [CNT_W-1:0] mism_cnt,
    output logic             mode_red
);
    import dlm_pkg::*;

    localparam logic [CW-1:0] LAST_BEAT = CW'(DEPTH - 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(DEPTH + 1);
    localparam logic [CW-1:0] N_FEED    = CW'(DEPTH);

    dlm_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic replay_q, bad_q, err_q, fatal_q, mode_q;
    logic [CNT_W-1:0] cnt_mm_q;
    logic run_end, bad_now, retry;

    assign in_ready  = (state_q == ST_LOAD);
    assign wr_en     = in_valid && in_ready;
    assign step      = cnt_q;
    assign p_en      = (state_q == ST_RUN) && (cnt_q < N_FEED);
    assign run_end   = (state_q == ST_RUN) && (cnt_q == LAST_STEP);
    assign bad_now   = bad_q | (mode_q & mism);
    assign retry     = run_end && bad_now && !replay_q;
    assign clr       = (wr_en && cnt_q == LAST_BEAT) || retry;
    assign out_valid = (state_q == ST_OUT0) || (state_q == ST_OUT1);
    assign out_tile  = (state_q == ST_OUT1);
    assign replay    = replay_q && (state_q == ST_RUN);
    assign err       = err_q;
    assign fatal     = fatal_q;
    assign mism_cnt  = cnt_mm_q;
    assign mode_red  = mode_q;

    // Tile state machine with replay and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            cnt_q    <= '0;
            replay_q <= 1'b0;
            bad_q    <= 1'b0;
            err_q    <= 1'b0;
            fatal_q  <= 1'b0;
            mode_q   <= 1'b0;
            cnt_mm_q <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (wr_en) begin
                        if (cnt_q == '0) mode_q <= mode_i;
                        if (cnt_q == LAST_BEAT) begin
                            state_q  <= ST_RUN;
                            cnt_q    <= '0;
                            replay_q <= 1'b0;
                            bad_q    <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (run_end) begin
                        cnt_q <= '0;
                        bad_q <= 1'b0;
                        if (bad_now) begin
                            err_q <= 1'b1;
                            if (cnt_mm_q != '1) cnt_mm_q <= cnt_mm_q + 1'b1;
                            if (replay_q) begin
                                fatal_q  <= 1'b1;
                                replay_q <= 1'b0;
                                state_q  <= ST_LOAD;
                            end else begin
                                replay_q <= 1'b1;
                            end
                        end else begin
                            replay_q <= 1'b0;
                            state_q  <= ST_OUT0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        bad_q <= bad_now;
                    end
                end
                ST_OUT0: state_q <= mode_q ? ST_LOAD : ST_OUT1;
                default: state_q <= ST_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/dual_lockstep_mac.sv
// Dual-subarray MAC engine: primary and shadow ROWS x SUB_COLS grids.
// They share a tile buffer. The shadow is fed one cycle after the primary.
// In lockstep mode, the primary accumulators are delayed one stage and
// compared with the shadow every cycle.
// Assumes DEPTH >= 2 and is a power of two.
module dual_lockstep_mac #(
    parameter int ROWS     = 4,
    parameter int SUB_COLS = 2,
    parameter int DW       = 8,
    parameter int DEPTH    = 4,
    parameter int CNT_W    = 8,
    localparam int ACC_W   = 2*DW + $clog2(DEPTH) + 1,
    localparam int TW      = ROWS*SUB_COLS*ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_i,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ROWS*DW-1:0]      in_a,
    input  logic [2*SUB_COLS*DW-1:0] in_b,
    input  logic                    fault_i,
    output logic                    out_valid,
    output logic                    out_tile,
    output logic [TW-1:0]           out_data,
    output logic                    replay_o,
    output logic                    err_o,
    output logic                    fatal_o,
    output logic [CNT_W-1:0]        mism_cnt_o
);
    localparam int AWD = ROWS*DW;
    localparam int HB  = SUB_COLS*DW;
    localparam int BW  = 2*HB;
    localparam int OPW = AWD + BW;
    localparam int IW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 2);

    logic          wr_en, p_en, clr, mism, mode_red;
    logic [CW-1:0] step;
    logic [OPW-1:0] rd_data;
    logic [AWD-1:0] rd_a, s_a_q;
    logic [BW-1:0]  rd_b;
    logic [HB-1:0]  s_src_b, s_b_q;
    logic           s_en_q;
    logic [TW-1:0]  p_acc, p_acc_d, s_acc;

    lockstep_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode_i),
        .mism(mism), .in_ready(in_ready), .wr_en(wr_en), .step(step),
        .p_en(p_en), .clr(clr), .out_valid(out_valid), .out_tile(out_tile),
        .replay(replay_o), .err(err_o), .fatal(fatal_o),
        .mism_cnt(mism_cnt_o), .mode_red(mode_red)
    );

    op_buffer #(.DEPTH(DEPTH), .WIDTH(OPW)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_idx(step[IW-1:0]),
        .wr_data({in_b, in_a}), .rd_idx(step[IW-1:0]), .rd_data(rd_data)
    );

    assign rd_a    = rd_data[AWD-1:0];
    assign rd_b    = rd_data[OPW-1:AWD];
    assign s_src_b = mode_red ? rd_b[HB-1:0] : rd_b[BW-1:HB];

    // Shadow sequencer: the same operand stream, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_en_q <= 1'b0;
            s_a_q  <= '0;
            s_b_q  <= '0;
        end else begin
            s_en_q <= p_en;
            s_a_q  <= rd_a;
            s_b_q  <= s_src_b;
        end
    end

    mac_subarray #(.ROWS(ROWS), .COLS(SUB_COLS), .DW(DW), .ACC_W(ACC_W)) u_primary (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(p_en), .flip(fault_i),
        .a(rd_a), .b(rd_b[HB-1:0]), .acc(p_acc)
    );

    mac_subarray #(.ROWS(ROWS), .COLS(SUB_COLS), .DW(DW), .ACC_W(ACC_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(s_en_q), .flip(1'b0),
        .a(s_a_q), .b(s_b_q), .acc(s_acc)
    );

    // Align primary results with the shadow's one-cycle lag.
    always_ff @(posedge clk) begin
        if (!rst_n)   p_acc_d <= '0;
        else if (clr) p_acc_d <= '0;
        else          p_acc_d <= p_acc;
    end

    assign mism     = (p_acc_d != s_acc);
    assign out_data = out_tile ? s_acc : p_acc;
endmodule

// File: rtl/dual_lockstep_mac_chk.sv
// Property checker for dual_lockstep_mac, attached by bind.
module dual_lockstep_mac_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_tile,
    input logic             err_o,
    input logic             fatal_o,
    input logic [CNT_W-1:0] mism_cnt_o,
    input logic             mode_red
);
    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R10
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);
    // R7
    fatal_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> err_o);
    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mism_cnt_o != $past(mism_cnt_o)) |-> (mism_cnt_o == $past(mism_cnt_o) + 1'b1));
    // R3
    tile1_split_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tile) |-> !mode_red);
    // R3
    tile1_follows_tile0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tile) |-> ($past(out_valid) && !$past(out_tile)));
endmodule

bind dual_lockstep_mac dual_lockstep_mac_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_tile(out_tile), .err_o(err_o), .fatal_o(fatal_o),
    .mism_cnt_o(mism_cnt_o), .mode_red(mode_red)
);

// File: tb/dual_lockstep_mac_tb.sv
// Scoreboard bench: the driver queues the expected tiles, and the monitor compares the results as they appear.
module dual_lockstep_mac_tb;
    localparam int ROWS  = 4;
    localparam int SC    = 2;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int CNT_W = 8;
    localparam int ACC_W = 2*DW + $clog2(DEPTH) + 1;
    localparam int TW    = ROWS*SC*ACC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0, in_valid = 1'b0, fault_i = 1'b0;
    logic [ROWS*DW-1:0] in_a = '0;
    logic [2*SC*DW-1:0] in_b = '0;
    logic in_ready, out_valid, out_tile, replay_o, err_o, fatal_o;
    logic [TW-1:0] out_data;
    logic [CNT_W-1:0] mism_cnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int exp_cnt = 0;
    bit exp_err = 1'b0, exp_fatal = 1'b0;

    logic [TW-1:0] exp_q[$];
    logic          exp_id_q[$];
    string         exp_tag_q[$];
    logic [7:0] va [DEPTH][ROWS];
    logic [7:0] vb [DEPTH][4];

    always #2 clk = ~clk;

    dual_lockstep_mac #(.ROWS(ROWS), .SUB_COLS(SC), .DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .fault_i(fault_i),
        .out_valid(out_valid), .out_tile(out_tile), .out_data(out_data),
        .replay_o(replay_o), .err_o(err_o), .fatal_o(fatal_o), .mism_cnt_o(mism_cnt_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pop and compare each emitted result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R7 unexpected result act=%h exp=none", out_data);
            end else begin
                logic [TW-1:0] e;
                logic ei;
                string t;
                e = exp_q.pop_front();
                ei = exp_id_q.pop_front();
                t = exp_tag_q.pop_front();
                if (out_data !== e || out_tile !== ei) begin
                    failures++;
                    $display("FAIL %s tile id act=%0d exp=%0d data act=%h exp=%h",
                             t, out_tile, ei, out_data, e);
                end
            end
        end
    end

    // Drive one tile; fkind 0 = clean, 1 = single-cycle fault, 2 = fault held over both passes.
    task automatic run_tile(input bit red, input int pat, input int fkind, input string tag);
        int k;
        bit saw_replay;
        for (int b = 0; b < DEPTH; b++) begin
            for (int r = 0; r < ROWS; r++)
                va[b][r] = (pat == 99) ? 8'hFF : 8'(pat*29 + b*13 + r*7 + 3);
            for (int c = 0; c < 4; c++)
                vb[b][c] = (pat == 99) ? 8'hFF : 8'(pat*17 + b*5 + c*31 + 9);
        end
        if (fkind != 2 || !red) begin
            for (int t = 0; t < (red ? 1 : 2); t++) begin
                logic [TW-1:0] tile;
                tile = '0;
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < SC; c++) begin
                        longint s;
                        s = 0;
                        for (int b = 0; b < DEPTH; b++) begin
                            longint p;
                            p = longint'(va[b][r]) * longint'(vb[b][c + SC*t]);
                            if (b == 0 && r == 0 && c == 0 && t == 0 && fkind == 1 && !red) p = p ^ 1;
                            s += p;
                        end
                        tile[(r*SC+c)*ACC_W +: ACC_W] = ACC_W'(s);
                    end
                exp_q.push_back(tile);
                exp_id_q.push_back(t[0]);
                exp_tag_q.push_back(tag);
            end
        end
        if (red && fkind == 1) begin exp_cnt += 1; exp_err = 1'b1; end
        if (red && fkind == 2) begin exp_cnt += 2; exp_err = 1'b1; exp_fatal = 1'b1; end

        for (int b = 0; b < DEPTH; b++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            mode_i = (b == 0) ? red : ~red;
            for (int r = 0; r < ROWS; r++) in_a[r*8 +: 8] = va[b][r];
            for (int c = 0; c < 4; c++)    in_b[c*8 +: 8] = vb[b][c];
            @(posedge clk);
        end
        k = 0;
        saw_replay = 1'b0;
        forever begin
            @(negedge clk);
            if (k == 0) begin
                in_valid = 1'b0;
                fault_i = (fkind != 0);
                // R9 the engine stops taking beats once the tile is loaded
                check(!in_ready, {tag, " R9 in_ready while computing"}, in_ready, 0);
            end
            if (fkind == 1 && k == 1) fault_i = 1'b0;
            if (fkind == 2 && k == 2*DEPTH + 6) fault_i = 1'b0;
            if (replay_o) saw_replay = 1'b1;
            if (out_valid) break;
            k++;
            if (k > 40) break;
        end
        fault_i = 1'b0;
        if (fkind == 0)
            check(k == DEPTH + 2, {tag, " R6 clean latency"}, k, DEPTH + 2);
        else if (fkind == 1 && red) begin
            check(k <= 100 && k > DEPTH + 2, {tag, " R6 replay latency"}, k, 2*(DEPTH + 2));
            check(saw_replay, {tag, " R5 replay_o seen"}, saw_replay, 1);
        end else if (fkind == 2 && red)
            check(k > 40, {tag, " R7 tile dropped"}, k, 41);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {tag, " R3 all results emitted"}, exp_q.size(), 0);
        check(err_o == exp_err, {tag, " R5 err_o"}, err_o, exp_err);
        check(fatal_o == exp_fatal, {tag, " R7 fatal_o"}, fatal_o, exp_fatal);
        check(mism_cnt_o == CNT_W'(exp_cnt), {tag, " R5 mism_cnt_o"}, mism_cnt_o, exp_cnt);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=hung exp=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(err_o == 1'b0, "R1 err_o", err_o, 0);
        check(fatal_o == 1'b0, "R1 fatal_o", fatal_o, 0);
        check(mism_cnt_o == '0, "R1 mism_cnt_o", mism_cnt_o, 0);
        check(replay_o == 1'b0, "R1 replay_o", replay_o, 0);

        run_tile(1'b1, 1, 0, "R2 R4 lockstep clean");
        run_tile(1'b0, 2, 0, "R3 R4 split clean");
        run_tile(1'b1, 3, 1, "R5 lockstep fault replay");
        run_tile(1'b0, 4, 1, "R8 split fault undetected");
        run_tile(1'b1, 5, 2, "R7 double mismatch");
        run_tile(1'b1, 6, 0, "R10 lockstep after fatal");
        run_tile(1'b0, 99, 0, "R3 split max operands");
        run_tile(1'b1, 99, 0, "R2 lockstep max operands");
        summary();
    end
endmodule